// File: doc/BRIEF.md
# Imaging Front-End Control Register Bank

This block stores the programmable settings of a three-channel imaging front end: one configuration word, a signal offset for each of the red, green and blue channels, and a gain for each channel. The stored values go straight to downstream logic as parallel outputs. A host writes the registers through one of two access paths, chosen by two mode pins. The first path is a three-wire serial link with a data line, a shift clock and a write strobe. The second is a parallel port that borrows the eight data pins the converter uses for its output.

All host-side pins are asynchronous to the block clock and pass through a synchronizer first. A write takes effect on the rising edge of the write strobe. The mode pins also decide whether the shared data pins carry converter samples out of the chip or are released so the host can drive them. One mode code is illegal. While it is applied, the block makes no writes and releases the pins.

Top module: `fe_ctrl_regs`

## Requirements
- R1: While reset is low at a clock edge, the configuration word reads 00h after that edge (3-channel correlated-sampling mode, internal reference, red-green-blue order), every offset reads C0h (zero offset) and every gain reads 00h (unity).
- R2: Address 0 selects the configuration word. Addresses 1, 2 and 3 select the red, green and blue offsets. Addresses 4, 5 and 6 select the red, green and blue gains. A write changes only the addressed register.
- R3: The configuration word keeps data bits 6:0 and a gain keeps data bits 4:0. The upper data bits are discarded.
- R4: A write to address 7 changes no register.
- R5: With mode pins {oe,ps} = 00, bus_oe is 1 and bus_out follows conv_data. Register writes come from the serial path.
- R6: With mode pins 10, bus_oe is 0 and register writes come from the serial path.
- R7: With mode pins 11, bus_oe is 0. A strobe rise writes bus_in to the register at par_addr, and serial frames are ignored.
- R8: With mode pins 01 (illegal), bus_oe is 0 and neither path writes any register.
- R9: A serial frame is 11 bits shifted MSB first on rising ser_clk edges: a 3-bit address, then 8 data bits. A strobe rise commits it.
- R10: A strobe rise writes nothing when a number of bits other than 11 has been shifted since the previous strobe rise. Every strobe rise restarts the bit count. A ser_clk rise that is seen in the same synchronized cycle as the strobe rise is discarded.
- R11: In the serial modes, par_addr and bus_in have no effect.
- R12: Registers hold their values when no write is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_oe | input | 1 | Mode pin, upper bit of the access-mode code |
| mode_ps | input | 1 | Mode pin, lower bit of the access-mode code |
| wr_strobe | input | 1 | Write strobe; a rising edge commits a write |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| par_addr | input | 3 | Parallel register address |
| bus_in | input | 8 | Value received on the shared data pins |
| conv_data | input | 8 | Converter sample to present on the shared pins |
| bus_out | output | 8 | Value driven onto the shared data pins |
| bus_oe | output | 1 | Output enable for the shared data pins |
| cfg_word | output | 7 | Configuration register |
| offset_red | output | 8 | Red offset register |
| offset_green | output | 8 | Green offset register |
| offset_blue | output | 8 | Blue offset register |
| gain_red | output | 5 | Red gain register |
| gain_green | output | 5 | Green gain register |
| gain_blue | output | 5 | Blue gain register |

## Verification
A serial commit and a serial shift can fall in the same synchronized cycle. To provoke this, the bench shifts a complete 11-bit frame and then raises ser_clk and wr_strobe together. The bench expects the completed frame to be written and the coincident clock edge to be dropped. It judges the second half of that rule by sending a fresh 11-bit frame right afterwards: the fresh frame must also be accepted, which would fail if the dropped edge had been counted.

// File: rtl/fe_regs_pkg.sv
// Shared constants and types for the front-end control register bank.
// Assumes a 3-bit address space with one reserved code at the top.
package fe_regs_pkg;

    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int CFG_W      = 7;
    localparam int GAIN_W     = 5;
    localparam int NUM_CH     = 3;
    localparam int FRAME_BITS = ADDR_W + DATA_W;

    localparam logic [ADDR_W-1:0] ADDR_CFG       = 3'd0;
    localparam int                ADDR_OFS_BASE  = 1;
    localparam int                ADDR_GAIN_BASE = ADDR_OFS_BASE + NUM_CH;
    localparam logic [ADDR_W-1:0] ADDR_RSVD      = 3'd7;

    localparam logic [CFG_W-1:0]  CFG_RESET  = 7'h00;
    localparam logic [DATA_W-1:0] OFS_RESET  = 8'hC0;
    localparam logic [GAIN_W-1:0] GAIN_RESET = 5'h00;

    // Access-mode code formed as {mode_oe, mode_ps}
    typedef enum logic [1:0] {
        MODE_SER_OUT   = 2'b00,
        MODE_ILLEGAL   = 2'b01,
        MODE_SER_QUIET = 2'b10,
        MODE_PAR       = 2'b11
    } port_mode_e;

endpackage

// File: rtl/fe_pin_sync.sv
// Multi-stage synchronizer for a group of asynchronous host pins.
// Assumes each pin is individually tolerant of one cycle of skew.
module fe_pin_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the pin samples through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign pin_o = stage_q[STAGES-1];

endmodule

// File: rtl/fe_serial_rx.sv
// Serial frame receiver: shifts bits MSB first on synchronized clock
// rises and flags a frame of exactly FRAME_BITS bits. A commit pulse
// restarts the count and takes priority over a coincident shift.
module fe_serial_rx #(
    parameter int FRAME_BITS = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic                  sclk_rise,
    input  logic                  sdata,
    input  logic                  commit,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  frame_ok
);

    localparam int               CNT_W   = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_BITS);

    logic [FRAME_BITS-1:0] shift_q;
    logic [CNT_W-1:0]      cnt_q;

    // Shift data and count bits, saturating one past a full frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (commit) begin
            cnt_q <= '0;
        end else if (shift_en && sclk_rise) begin
            shift_q <= {shift_q[FRAME_BITS-2:0], sdata};
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign frame    = shift_q;
    assign frame_ok = (cnt_q == CNT_OK);

endmodule

// File: rtl/fe_write_decode.sv
// Selects the write source from the synchronized access mode and forms
// a single write request. The illegal mode yields no request.
module fe_write_decode
    import fe_regs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  port_mode_e        mode,
    input  logic              strobe_rise,
    input  logic [AW-1:0]     par_addr,
    input  logic [DW-1:0]     par_data,
    input  logic [AW+DW-1:0]  ser_frame,
    input  logic              ser_ok,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data
);

    // Choose the write source for the current mode
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = ser_frame[AW+DW-1:DW];
        wr_data = ser_frame[DW-1:0];
        unique case (mode)
            MODE_SER_OUT, MODE_SER_QUIET: begin
                wr_en = strobe_rise && ser_ok;
            end
            MODE_PAR: begin
                wr_en   = strobe_rise;
                wr_addr = par_addr;
                wr_data = par_data;
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fe_reg_file.sv
// Register storage: one configuration word plus an offset and a gain
// per channel. Narrow registers keep the low data bits. The reserved
// address matches no register.
module fe_reg_file
    import fe_regs_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [CFG_W-1:0]       cfg_q,
    output logic [CH*DATA_W-1:0]   ofs_q,
    output logic [CH*GAIN_W-1:0]   gain_q
);

    localparam int LAST_ADDR = ADDR_GAIN_BASE + CH - 1;

    if (LAST_ADDR >= int'(ADDR_RSVD)) begin : g_bad_map
        $error("channel count overlaps the reserved address");
    end

    // Configuration word update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en && wr_addr == ADDR_CFG) begin
            cfg_q <= wr_data[CFG_W-1:0];
        end
    end

    for (genvar ch = 0; ch < CH; ch++) begin : g_chan
        localparam logic [ADDR_W-1:0] OFS_ADDR  = ADDR_W'(ADDR_OFS_BASE + ch);
        localparam logic [ADDR_W-1:0] GAIN_ADDR = ADDR_W'(ADDR_GAIN_BASE + ch);
        logic [DATA_W-1:0] ofs_r;
        logic [GAIN_W-1:0] gain_r;

        // Per-channel offset update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ofs_r <= OFS_RESET;
            end else if (wr_en && wr_addr == OFS_ADDR) begin
                ofs_r <= wr_data;
            end
        end

        // Per-channel gain update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gain_r <= GAIN_RESET;
            end else if (wr_en && wr_addr == GAIN_ADDR) begin
                gain_r <= wr_data[GAIN_W-1:0];
            end
        end

        assign ofs_q[ch*DATA_W +: DATA_W]  = ofs_r;
        assign gain_q[ch*GAIN_W +: GAIN_W] = gain_r;
    end

endmodule

// File: rtl/fe_ctrl_regs.sv
// Top of the front-end control register bank. Synchronizes the host
// pins, detects strobe and serial clock rises, routes writes from the
// selected path and drives the shared data pins. Assumes par_addr and
// bus_in are held stable for the synchronizer delay around a strobe rise.
module fe_ctrl_regs
    import fe_regs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_oe,
    input  logic              mode_ps,
    input  logic              wr_strobe,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic [ADDR_W-1:0] par_addr,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] conv_data,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [CFG_W-1:0]  cfg_word,
    output logic [DATA_W-1:0] offset_red,
    output logic [DATA_W-1:0] offset_green,
    output logic [DATA_W-1:0] offset_blue,
    output logic [GAIN_W-1:0] gain_red,
    output logic [GAIN_W-1:0] gain_green,
    output logic [GAIN_W-1:0] gain_blue
);

    localparam int PIN_W = 5;

    logic [PIN_W-1:0]      pins_s;
    port_mode_e            mode_s;
    logic                  sclk_s, sdata_s, strobe_s;
    logic                  sclk_d, strobe_d;
    logic                  sclk_rise, strobe_rise;
    logic                  ser_en;
    logic [FRAME_BITS-1:0] ser_frame;
    logic                  ser_ok;
    logic                  wr_en;
    logic [ADDR_W-1:0]     wr_addr;
    logic [DATA_W-1:0]     wr_data;
    logic [NUM_CH*DATA_W-1:0] ofs_all;
    logic [NUM_CH*GAIN_W-1:0] gain_all;

    fe_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({mode_oe, mode_ps, ser_clk, ser_data, wr_strobe}),
        .pin_o (pins_s)
    );

    assign mode_s   = port_mode_e'(pins_s[4:3]);
    assign sclk_s   = pins_s[2];
    assign sdata_s  = pins_s[1];
    assign strobe_s = pins_s[0];

    // Delay registers for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            strobe_d <= 1'b0;
        end else begin
            sclk_d   <= sclk_s;
            strobe_d <= strobe_s;
        end
    end

    assign sclk_rise   = sclk_s & ~sclk_d;
    assign strobe_rise = strobe_s & ~strobe_d;
    assign ser_en      = (mode_s == MODE_SER_OUT) || (mode_s == MODE_SER_QUIET);

    fe_serial_rx #(.FRAME_BITS(FRAME_BITS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (ser_en),
        .sclk_rise (sclk_rise),
        .sdata     (sdata_s),
        .commit    (strobe_rise),
        .frame     (ser_frame),
        .frame_ok  (ser_ok)
    );

    fe_write_decode #(.AW(ADDR_W), .DW(DATA_W)) u_dec (
        .mode        (mode_s),
        .strobe_rise (strobe_rise),
        .par_addr    (par_addr),
        .par_data    (bus_in),
        .ser_frame   (ser_frame),
        .ser_ok      (ser_ok),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    fe_reg_file #(.CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_q   (cfg_word),
        .ofs_q   (ofs_all),
        .gain_q  (gain_all)
    );

    assign offset_red   = ofs_all[0*DATA_W +: DATA_W];
    assign offset_green = ofs_all[1*DATA_W +: DATA_W];
    assign offset_blue  = ofs_all[2*DATA_W +: DATA_W];
    assign gain_red     = gain_all[0*GAIN_W +: GAIN_W];
    assign gain_green   = gain_all[1*GAIN_W +: GAIN_W];
    assign gain_blue    = gain_all[2*GAIN_W +: GAIN_W];

    // Shared-pin drive: only the output-enabled serial mode drives the pins
    always_comb begin
        bus_oe  = ({mode_oe, mode_ps} == MODE_SER_OUT);
        bus_out = bus_oe ? conv_data : '0;
    end

endmodule

// File: rtl/fe_ctrl_regs_chk.sv
// Assertion checker for fe_ctrl_regs, attached by bind below.
module fe_ctrl_regs_chk
    import fe_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_oe,
    input logic              mode_ps,
    input port_mode_e        mode_s,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_out,
    input logic [DATA_W-1:0] conv_data,
    input logic [CFG_W-1:0]  cfg_word,
    input logic [DATA_W-1:0] offset_red,
    input logic [DATA_W-1:0] offset_green,
    input logic [DATA_W-1:0] offset_blue,
    input logic [GAIN_W-1:0] gain_red,
    input logic [GAIN_W-1:0] gain_green,
    input logic [GAIN_W-1:0] gain_blue
);

    logic [CFG_W+3*DATA_W+3*GAIN_W-1:0] all_regs;
    assign all_regs = {cfg_word, offset_red, offset_green, offset_blue,
                       gain_red, gain_green, gain_blue};

    p_reset_defaults_r1: assert property (@(posedge clk)
        !rst_n |=> (cfg_word == CFG_RESET && offset_red == OFS_RESET &&
                    offset_green == OFS_RESET && offset_blue == OFS_RESET &&
                    gain_red == GAIN_RESET && gain_green == GAIN_RESET &&
                    gain_blue == GAIN_RESET));

    p_reserved_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_RSVD) |=> $stable(all_regs));

    p_bus_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_oe, mode_ps} == 2'b00) |-> (bus_oe && bus_out == conv_data));

    p_bus_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_oe, mode_ps} == 2'b10) |-> !bus_oe);

    p_bus_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_oe, mode_ps} == 2'b11) |-> !bus_oe);

    p_illegal_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s == MODE_ILLEGAL) |-> !wr_en);

    p_illegal_bus_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_oe, mode_ps} == 2'b01) |-> !bus_oe);

    p_hold_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(all_regs));

endmodule

bind fe_ctrl_regs fe_ctrl_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_oe      (mode_oe),
    .mode_ps      (mode_ps),
    .mode_s       (mode_s),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .bus_oe       (bus_oe),
    .bus_out      (bus_out),
    .conv_data    (conv_data),
    .cfg_word     (cfg_word),
    .offset_red   (offset_red),
    .offset_green (offset_green),
    .offset_blue  (offset_blue),
    .gain_red     (gain_red),
    .gain_green   (gain_green),
    .gain_blue    (gain_blue)
);

// File: tb/tb_fe_ctrl_regs.sv
module tb_fe_ctrl_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_oe = 1'b0, mode_ps = 1'b0;
    logic       wr_strobe = 1'b0, ser_clk = 1'b0, ser_data = 1'b0;
    logic [2:0] par_addr = '0;
    logic [7:0] bus_in = '0, conv_data = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [6:0] cfg_word;
    logic [7:0] offset_red, offset_green, offset_blue;
    logic [4:0] gain_red, gain_green, gain_blue;

    always #10 clk = ~clk;

    fe_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .mode_oe(mode_oe), .mode_ps(mode_ps),
        .wr_strobe(wr_strobe), .ser_clk(ser_clk), .ser_data(ser_data),
        .par_addr(par_addr), .bus_in(bus_in), .conv_data(conv_data),
        .bus_out(bus_out), .bus_oe(bus_oe), .cfg_word(cfg_word),
        .offset_red(offset_red), .offset_green(offset_green),
        .offset_blue(offset_blue), .gain_red(gain_red),
        .gain_green(gain_green), .gain_blue(gain_blue)
    );

    typedef struct {
        string      req;
        logic [6:0] cfg;
        logic [7:0] ofs [3];
        logic [4:0] gain [3];
    } snap_t;

    snap_t      sb_q [$];
    logic [6:0] m_cfg;
    logic [7:0] m_ofs [3];
    logic [4:0] m_gain [3];
    int         n_checks = 0, n_fail = 0;
    bit         done = 0;

    task automatic model_reset();
        m_cfg = 7'h00;
        for (int i = 0; i < 3; i++) begin m_ofs[i] = 8'hC0; m_gain[i] = 5'h00; end
    endtask

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        if (a == 3'd0) m_cfg = d[6:0];
        else if (a <= 3'd3) m_ofs[a-1] = d;
        else if (a <= 3'd6) m_gain[a-4] = d[4:0];
    endtask

    task automatic push_expect(input string req);
        snap_t s;
        s.req = req; s.cfg = m_cfg;
        for (int i = 0; i < 3; i++) begin s.ofs[i] = m_ofs[i]; s.gain[i] = m_gain[i]; end
        sb_q.push_back(s);
        @(posedge clk); @(posedge clk);
    endtask

    // Monitor: pop expected snapshots and compare against the outputs
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            snap_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (cfg_word !== e.cfg || offset_red !== e.ofs[0] || offset_green !== e.ofs[1] ||
                offset_blue !== e.ofs[2] || gain_red !== e.gain[0] ||
                gain_green !== e.gain[1] || gain_blue !== e.gain[2]) begin
                n_fail++;
                $display("FAIL %s: got cfg=%h ofs=%h/%h/%h gain=%h/%h/%h exp cfg=%h ofs=%h/%h/%h gain=%h/%h/%h",
                    e.req, cfg_word, offset_red, offset_green, offset_blue,
                    gain_red, gain_green, gain_blue, e.cfg, e.ofs[0], e.ofs[1],
                    e.ofs[2], e.gain[0], e.gain[1], e.gain[2]);
            end
        end
    end

    task automatic check_bus(input string req, input logic exp_oe, input logic [7:0] exp_out);
        @(negedge clk);
        n_checks++;
        if (bus_oe !== exp_oe || (exp_oe && bus_out !== exp_out)) begin
            n_fail++;
            $display("FAIL %s: got oe=%b out=%h exp oe=%b out=%h", req, bus_oe, bus_out, exp_oe, exp_out);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic set_mode(input logic oe, input logic ps);
        mode_oe = oe; mode_ps = ps;
        wait_cyc(5);
    endtask

    task automatic strobe();
        wr_strobe = 1'b1; wait_cyc(6);
        wr_strobe = 1'b0; wait_cyc(4);
    endtask

    task automatic par_write(input logic [2:0] a, input logic [7:0] d);
        par_addr = a; bus_in = d;
        wait_cyc(2);
        strobe();
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            wait_cyc(3);
            ser_clk = 1'b1; wait_cyc(3);
            ser_clk = 1'b0;
        end
        wait_cyc(3);
    endtask

    task automatic ser_write(input logic [2:0] a, input logic [7:0] d);
        shift_bits({5'b0, a, d}, 11);
        strobe();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        model_reset();
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        push_expect("R1 defaults after reset");

        conv_data = 8'h5A;
        check_bus("R5 bus drives converter data", 1'b1, 8'h5A);
        conv_data = 8'hA3;
        check_bus("R5 bus follows second pattern", 1'b1, 8'hA3);

        // Parallel mode, address map and truncation
        set_mode(1'b1, 1'b1);
        check_bus("R7 bus released in parallel mode", 1'b0, 8'h00);
        par_write(3'd1, 8'h11); model_write(3'd1, 8'h11); push_expect("R2 red offset");
        par_write(3'd2, 8'h22); model_write(3'd2, 8'h22); push_expect("R2 green offset");
        par_write(3'd3, 8'h33); model_write(3'd3, 8'h33); push_expect("R2 blue offset");
        par_write(3'd4, 8'hFF); model_write(3'd4, 8'hFF); push_expect("R3 red gain truncated");
        par_write(3'd5, 8'h0A); model_write(3'd5, 8'h0A); push_expect("R2 green gain");
        par_write(3'd6, 8'hF5); model_write(3'd6, 8'hF5); push_expect("R3 blue gain truncated");
        par_write(3'd0, 8'hFF); model_write(3'd0, 8'hFF); push_expect("R3 cfg truncated");
        par_write(3'd7, 8'h55); push_expect("R4 reserved address ignored");

        // Serial frame shifted while in parallel mode is ignored
        shift_bits({5'b0, 3'd1, 8'h99}, 11);
        par_addr = 3'd2; bus_in = 8'h44;
        wait_cyc(2);
        strobe(); model_write(3'd2, 8'h44);
        push_expect("R7 parallel write wins, serial ignored");

        // Quiet serial mode
        set_mode(1'b1, 1'b0);
        check_bus("R6 bus released in quiet serial mode", 1'b0, 8'h00);
        par_addr = 3'd3; bus_in = 8'h77;
        ser_write(3'd1, 8'hA5); model_write(3'd1, 8'hA5);
        push_expect("R9 R11 serial write, parallel pins ignored");

        // Output-enabled serial mode
        set_mode(1'b0, 1'b0);
        conv_data = 8'h3C;
        check_bus("R5 bus drives in serial mode", 1'b1, 8'h3C);
        ser_write(3'd5, 8'h1C); model_write(3'd5, 8'h1C);
        push_expect("R5 R9 serial write green gain");

        // Short and long frames
        shift_bits({6'b0, 10'h2AA}, 10); strobe();
        push_expect("R10 short frame discarded");
        shift_bits({4'b0, 12'hFFF}, 12); strobe();
        push_expect("R10 long frame discarded");
        ser_write(3'd3, 8'h6E); model_write(3'd3, 8'h6E);
        push_expect("R10 count restarts after rejected frame");

        // Illegal mode
        set_mode(1'b0, 1'b1);
        check_bus("R8 bus released in illegal mode", 1'b0, 8'h00);
        par_write(3'd1, 8'h01);
        push_expect("R8 parallel write blocked");
        ser_write(3'd2, 8'h02);
        push_expect("R8 serial write blocked");

        // Strobe and serial clock rise together
        set_mode(1'b0, 1'b0);
        shift_bits({5'b0, 3'd6, 8'h03}, 11);
        ser_data = 1'b1;
        wait_cyc(2);
        ser_clk = 1'b1; wr_strobe = 1'b1;
        wait_cyc(6);
        ser_clk = 1'b0; wr_strobe = 1'b0;
        wait_cyc(4);
        model_write(3'd6, 8'h03);
        push_expect("R10 commit with coincident shift");
        ser_write(3'd0, 8'h2A); model_write(3'd0, 8'h2A);
        push_expect("R10 coincident bit not counted");

        // Hold with serial clock activity and no strobe
        shift_bits(16'hFFFF, 16);
        wait_cyc(20);
        push_expect("R12 registers hold without strobe");

        // Reset again mid-run
        rst_n = 1'b0; wait_cyc(3); rst_n = 1'b1; wait_cyc(1);
        model_reset();
        push_expect("R1 defaults after second reset");

        wait_cyc(5);
        finish_run();
    end

endmodule